// File: doc/BRIEF.md
# Serial flash controller FIFO data port

This block sits between a memory-mapped register bus and the frame engine of a serial flash controller. It holds a 16-byte transmit queue and a 16-byte receive queue. It also holds the control, frame-count and interrupt-enable registers, and it builds a status word from its own queue state and from the state the engine reports. On the engine side it offers one byte stream in each direction. Clock divider, clock idle level, enable and frame counts are passed to the engine unchanged.

Software moves data through the queues in one of two widths, chosen by control bit 16. When the bit is clear, the byte data registers move one byte per access. When it is set, the word data registers move four bytes per access, packed little-endian. An access to the data register of the width that is not selected does nothing. A word read with fewer than four bytes queued returns zero and takes nothing out. Software polls the status word and retries the read.

Top module: `qspi_fifo_port`

## Requirements
- R1: After reset both queues are empty, control reads 0, `eng_tx_valid` and `irq` are low, and status reads 0x098 when `eng_ready` is high and the engine done inputs are low.
- R2: With control bit 16 clear, a write to offset 0x44 queues `bus_wdata[7:0]` and ignores the upper bits. Queued bytes leave on `eng_tx_data` in write order, one for each cycle in which `eng_tx_valid` and `eng_tx_ready` are both high.
- R3: With control bit 16 set, a write to offset 0x4C queues four bytes, bits 7:0 first and bits 31:24 last.
- R4: With control bit 16 clear, a read of offset 0x40 returns the oldest received byte in bits 7:0 with bits 31:8 zero, and removes that byte.
- R5: With control bit 16 set, a read of offset 0x48 with at least four bytes queued returns them little-endian, the oldest in bits 7:0, and removes four. With fewer than four queued it returns 0 and removes none.
- R6: An access to the byte data registers (0x40, 0x44) while bit 16 is set, or to the word data registers (0x48, 0x4C), while it is clear, queues nothing, removes nothing and reads 0.
- R7: A transmit write that does not fit (byte write with 16 queued, word write with fewer than 4 free) is dropped and sets status bit 6. Bit 6 stays set until a status write (offset 0x10) with bit 6 high.
- R8: A byte read of an empty receive queue returns 0 and leaves the queue unchanged.
- R9: Status (0x10) bits are: 0 engine transmit done, 1 engine receive done, 2 receive byte available, 3 transmit slot free, 4 receive queue empty, 5 transmit queue full, 6 overflow, 7 engine ready, 8 a copy of control bit 16.
- R10: Interrupt enable (0x0C, bits 5:0) masks status bits 5:0. `irq` is a registered OR of the enabled bits and follows them within two cycles.
- R11: `cfg_enable` is control bit 0, `cfg_clk_idle` is bit 10 and `cfg_clk_div` is bits 27:24. Frames (0x04, 32 bits) and upper frame count (0x50, 16 bits) read back and drive `cfg_frames` and `cfg_frames_up`.
- R12: `eng_rx_ready` is low while 16 bytes are in the receive queue, and a byte offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_ready | input | 1 | Engine takes the byte this cycle |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_valid | input | 1 | Received byte offered |
| eng_rx_ready | output | 1 | Receive queue has room |
| eng_tx_done | input | 1 | Engine transmit finished |
| eng_rx_done | input | 1 | Engine receive finished |
| eng_ready | input | 1 | Engine idle and ready |
| cfg_enable | output | 1 | Controller enable |
| cfg_clk_idle | output | 1 | Serial clock idle level |
| cfg_clk_div | output | 4 | Serial clock divider |
| cfg_frames | output | 32 | Frames register |
| cfg_frames_up | output | 16 | Upper frame count |
| irq | output | 1 | Interrupt request |

## Verification
Transmit data is written as byte sequences whose upper write bits hold junk, and as packed words whose four bytes all differ, so a swapped lane order or a leaked upper bit shows up in the engine stream. Reads check zero-extension and packing. They are made with zero, one, three and four bytes queued, which separates a correct four-byte threshold from an off-by-one or a partial pop. Each data register is also accessed in the width mode that is not selected, to check that nothing moves. Both queues are filled to the brim and one past it, covering the full, overflow and back-pressure cases. The status word and the interrupt are checked against engine inputs and enable masks that are switched one at a time.

// File: rtl/qspi_port_pkg.sv
package qspi_port_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAMES = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RXB    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_TXB    = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_RXW    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_TXW    = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_FRUP   = 8'h50;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IDLE_BIT = 10;
  localparam int CTRL_WORD_BIT = 16;
  localparam int CTRL_DIV_LSB  = 24;
  localparam int DIV_W         = 4;
  localparam int FRUP_W        = 16;

  localparam int STAT_W        = 9;
  localparam int IEN_W         = 6;
  localparam int ST_TXDONE  = 0;
  localparam int ST_RXDONE  = 1;
  localparam int ST_RXAVAIL = 2;
  localparam int ST_TXSPACE = 3;
  localparam int ST_RXEMPTY = 4;
  localparam int ST_TXFULL  = 5;
  localparam int ST_OVF     = 6;
  localparam int ST_READY   = 7;
  localparam int ST_WORD    = 8;
endpackage

// File: rtl/qspi_byte_fifo.sv
module qspi_byte_fifo #(
  parameter int DEPTH     = 16,
  parameter int IN_LANES  = 1,
  parameter int OUT_LANES = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NIW   = $clog2(IN_LANES + 1),
  localparam int NOW   = $clog2(OUT_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NIW-1:0]          push_n,
  input  logic [8*IN_LANES-1:0]   push_data,
  input  logic [NOW-1:0]          pop_n,
  output logic [8*OUT_LANES-1:0]  peek,
  output logic [CNT_W-1:0]        count
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // storage carries no reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    for (int l = 0; l < IN_LANES; l++) begin
      if (NIW'(l) < push_n) mem[wr_ptr + PTR_W'(l)] <= push_data[8*l +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(push_n);
      rd_ptr <= rd_ptr + PTR_W'(pop_n);
      count  <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  always_comb begin
    for (int l = 0; l < OUT_LANES; l++) peek[8*l +: 8] = mem[rd_ptr + PTR_W'(l)];
  end
endmodule

// File: rtl/qspi_port_regs.sv
module qspi_port_regs
  import qspi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] frames,
  output logic [FRUP_W-1:0] frames_up,
  output logic [IEN_W-1:0]  ien
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      frames    <= '0;
      frames_up <= '0;
      ien       <= '0;
    end else if (wr) begin
      case (addr)
        OFS_CTRL:   ctrl      <= wdata;
        OFS_FRAMES: frames    <= wdata;
        OFS_FRUP:   frames_up <= wdata[FRUP_W-1:0];
        OFS_IEN:    ien       <= wdata[IEN_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qspi_fifo_port.sv
module qspi_fifo_port
  import qspi_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int NOW   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        eng_tx_data,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  input  logic [7:0]        eng_rx_data,
  input  logic              eng_rx_valid,
  output logic              eng_rx_ready,
  input  logic              eng_tx_done,
  input  logic              eng_rx_done,
  input  logic              eng_ready,
  output logic              cfg_enable,
  output logic              cfg_clk_idle,
  output logic [DIV_W-1:0]  cfg_clk_div,
  output logic [DATA_W-1:0] cfg_frames,
  output logic [FRUP_W-1:0] cfg_frames_up,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [IEN_W-1:0]  ien_q;
  logic              word_mode;

  qspi_port_regs regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl(ctrl_q), .frames(cfg_frames), .frames_up(cfg_frames_up), .ien(ien_q)
  );

  assign word_mode    = ctrl_q[CTRL_WORD_BIT];
  assign cfg_enable   = ctrl_q[CTRL_EN_BIT];
  assign cfg_clk_idle = ctrl_q[CTRL_IDLE_BIT];
  assign cfg_clk_div  = ctrl_q[CTRL_DIV_LSB +: DIV_W];

  // transmit side: bus pushes one or four bytes, engine drains one
  logic [CNT_W-1:0]  tx_cnt;
  logic [CNT_W-1:0]  tx_free;
  logic [NOW-1:0]    tx_push_n;
  logic [DATA_W-1:0] tx_push_data;
  logic [0:0]        tx_pop_n;
  logic              wr_tx_byte, wr_tx_word, tx_drop;

  assign wr_tx_byte = bus_wr && (bus_addr == OFS_TXB) && !word_mode;
  assign wr_tx_word = bus_wr && (bus_addr == OFS_TXW) && word_mode;
  assign tx_free    = CNT_W'(DEPTH) - tx_cnt;

  always_comb begin
    tx_push_n    = '0;
    tx_push_data = bus_wdata;
    tx_drop      = 1'b0;
    if (wr_tx_byte) begin
      tx_push_data = {{(DATA_W-BYTE_W){1'b0}}, bus_wdata[BYTE_W-1:0]};
      if (tx_free != '0) tx_push_n = NOW'(1);
      else               tx_drop   = 1'b1;
    end else if (wr_tx_word) begin
      if (tx_free >= CNT_W'(LANES)) tx_push_n = NOW'(LANES);
      else                          tx_drop   = 1'b1;
    end
  end

  assign eng_tx_valid = (tx_cnt != '0);
  assign tx_pop_n     = eng_tx_valid && eng_tx_ready;

  qspi_byte_fifo #(.DEPTH(DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) tx_fifo_i (
    .clk(clk), .rst(rst), .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .peek(eng_tx_data), .count(tx_cnt)
  );

  // receive side: engine pushes one byte, bus drains one or four
  logic [CNT_W-1:0]  rx_cnt;
  logic [0:0]        rx_push_n;
  logic [NOW-1:0]    rx_pop_n;
  logic [DATA_W-1:0] rx_peek;
  logic              rd_rx_byte, rd_rx_word, rx_take_byte, rx_take_word;

  assign eng_rx_ready = (rx_cnt != CNT_W'(DEPTH));
  assign rx_push_n    = eng_rx_valid && eng_rx_ready;

  assign rd_rx_byte   = bus_rd && (bus_addr == OFS_RXB) && !word_mode;
  assign rd_rx_word   = bus_rd && (bus_addr == OFS_RXW) && word_mode;
  assign rx_take_byte = rd_rx_byte && (rx_cnt != '0);
  assign rx_take_word = rd_rx_word && (rx_cnt >= CNT_W'(LANES));
  assign rx_pop_n     = rx_take_word ? NOW'(LANES) : (rx_take_byte ? NOW'(1) : '0);

  qspi_byte_fifo #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) rx_fifo_i (
    .clk(clk), .rst(rst), .push_n(rx_push_n), .push_data(eng_rx_data),
    .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
  );

  // sticky overflow flag, cleared by writing one to its status bit
  logic ovf_q;
  always_ff @(posedge clk) begin
    if (rst)                                                      ovf_q <= 1'b0;
    else if (tx_drop)                                             ovf_q <= 1'b1;
    else if (bus_wr && bus_addr == OFS_STAT && bus_wdata[ST_OVF]) ovf_q <= 1'b0;
  end

  logic [STAT_W-1:0] stat;
  always_comb begin
    stat             = '0;
    stat[ST_TXDONE]  = eng_tx_done;
    stat[ST_RXDONE]  = eng_rx_done;
    stat[ST_RXAVAIL] = (rx_cnt != '0);
    stat[ST_TXSPACE] = (tx_free != '0);
    stat[ST_RXEMPTY] = (rx_cnt == '0);
    stat[ST_TXFULL]  = (tx_free == '0);
    stat[ST_OVF]     = ovf_q;
    stat[ST_READY]   = eng_ready;
    stat[ST_WORD]    = word_mode;
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (bus_addr)
      OFS_CTRL:   rd_next = ctrl_q;
      OFS_FRAMES: rd_next = cfg_frames;
      OFS_FRUP:   rd_next = DATA_W'(cfg_frames_up);
      OFS_IEN:    rd_next = DATA_W'(ien_q);
      OFS_STAT:   rd_next = DATA_W'(stat);
      OFS_RXB:    if (rx_take_byte) rd_next = DATA_W'(rx_peek[BYTE_W-1:0]);
      OFS_RXW:    if (rx_take_word) rd_next = rx_peek;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      irq <= |(stat[IEN_W-1:0] & ien_q);
    end
  end
endmodule

// File: rtl/qspi_fifo_port_chk.sv
module qspi_fifo_port_chk
  import qspi_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_tx_valid,
  input logic              eng_tx_ready,
  input logic              eng_rx_valid,
  input logic              irq,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              word_mode,
  input logic              ovf_q,
  input logic [IEN_W-1:0]  ien_q
);
  always @(posedge clk) begin
    if (!rst) begin
      assert_tx_bound_R7: assert (tx_cnt <= CNT_W'(DEPTH) && rx_cnt <= CNT_W'(DEPTH))
        else $error("queue count beyond depth");
    end
  end

  assert_full_write_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_TXB && !word_mode && tx_cnt == CNT_W'(DEPTH)) |=> ovf_q);

  assert_short_word_read_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_RXW && word_mode && rx_cnt < CNT_W'(LANES) && !eng_rx_valid)
      |=> (bus_rdata == '0 && rx_cnt == $past(rx_cnt)));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);

  assert_tx_pop_R2: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_valid && eng_tx_ready && !bus_wr) |=> (tx_cnt == $past(tx_cnt) - CNT_W'(1)));
endmodule

bind qspi_fifo_port qspi_fifo_port_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
  .eng_rx_valid(eng_rx_valid), .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .word_mode(word_mode), .ovf_q(ovf_q), .ien_q(ien_q)
);

// File: tb/qspi_fifo_port_tb_top.sv
module qspi_fifo_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  eng_tx_data;
  logic        eng_tx_valid;
  logic        eng_tx_ready = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_rx_valid = 1'b0;
  logic        eng_rx_ready;
  logic        eng_tx_done = 1'b0, eng_rx_done = 1'b0, eng_ready = 1'b1;
  logic        cfg_enable, cfg_clk_idle;
  logic [3:0]  cfg_clk_div;
  logic [31:0] cfg_frames;
  logic [15:0] cfg_frames_up;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  qspi_fifo_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_data(eng_tx_data),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_rx_data(eng_rx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_tx_done(eng_tx_done),
    .eng_rx_done(eng_rx_done), .eng_ready(eng_ready), .cfg_enable(cfg_enable),
    .cfg_clk_idle(cfg_clk_idle), .cfg_clk_div(cfg_clk_div), .cfg_frames(cfg_frames),
    .cfg_frames_up(cfg_frames_up), .irq(irq)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); eng_rx_data = b; eng_rx_valid = 1'b1;
    @(negedge clk); eng_rx_valid = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic ok);
    @(negedge clk); ok = eng_tx_valid; b = eng_tx_data; eng_tx_ready = 1'b1;
    @(negedge clk); eng_tx_ready = 1'b0;
  endtask

  task automatic drain_count(output int n);
    logic [7:0] b; logic ok;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      tx_take(b, ok);
      if (ok) n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h10, d); check("R1 reset status", d, 32'h98);
    rd(8'h00, d); check("R1 reset control", d, 32'h0);
    check("R1 reset tx_valid/irq", {30'b0, eng_tx_valid, irq}, 32'h0);
  endtask

  task automatic t_byte_tx;
    logic [7:0] b; logic ok; logic [31:0] got;
    wr(8'h44, 32'hAABBCC11); wr(8'h44, 32'hFFFFFF22); wr(8'h44, 32'h00000033);
    got = '0;
    for (int i = 0; i < 3; i++) begin tx_take(b, ok); got[8*i +: 8] = b; end
    check("R2 byte tx order", got, 32'h00332211);
    check("R2 tx empty after drain", {31'b0, eng_tx_valid}, 32'h0);
  endtask

  task automatic t_word_tx;
    logic [7:0] b; logic ok; logic [31:0] got; logic [31:0] d;
    wr(8'h00, 32'h0001_0000);
    rd(8'h10, d); check("R9 status word-mode mirror", d, 32'h198);
    wr(8'h4C, 32'h44332211);
    got = '0;
    for (int i = 0; i < 4; i++) begin tx_take(b, ok); got[8*i +: 8] = b; end
    check("R3 word tx little-endian", got, 32'h44332211);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_mismatch;
    logic [31:0] d;
    wr(8'h00, 32'h0001_0000);
    wr(8'h44, 32'h55);
    repeat (2) @(negedge clk);
    check("R6 byte write in word mode not queued", {31'b0, eng_tx_valid}, 32'h0);
    rx_push(8'h5A);
    rd(8'h40, d); check("R6 byte read in word mode reads 0", d, 32'h0);
    rd(8'h10, d); check("R6 rx byte kept", d & 32'h4, 32'h4);
    wr(8'h00, 32'h0);
    wr(8'h4C, 32'h01020304);
    repeat (2) @(negedge clk);
    check("R6 word write in byte mode not queued", {31'b0, eng_tx_valid}, 32'h0);
    rd(8'h48, d); check("R6 word read in byte mode reads 0", d, 32'h0);
    rd(8'h40, d); check("R4 leftover byte", d, 32'h5A);
  endtask

  task automatic t_rx_byte;
    logic [31:0] d;
    rx_push(8'hA1); rx_push(8'hB2);
    rd(8'h40, d); check("R4 first rx byte zero-extended", d, 32'hA1);
    rd(8'h40, d); check("R4 second rx byte", d, 32'hB2);
    rd(8'h40, d); check("R8 empty read returns 0", d, 32'h0);
    rd(8'h10, d); check("R8 status after empty read", d, 32'h98);
  endtask

  task automatic t_rx_word;
    logic [31:0] d;
    wr(8'h00, 32'h0001_0000);
    rx_push(8'h01); rx_push(8'h02); rx_push(8'h03);
    rd(8'h48, d); check("R5 short word read returns 0", d, 32'h0);
    rd(8'h10, d); check("R5 three bytes kept", d, 32'h18C);
    rx_push(8'h04);
    rd(8'h48, d); check("R5 word read little-endian", d, 32'h04030201);
    rd(8'h10, d); check("R5 four bytes removed", d, 32'h198);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_overflow;
    logic [31:0] d; logic [7:0] b; logic ok; int bad; int n;
    for (int i = 0; i < 16; i++) wr(8'h44, 32'h80 + i);
    rd(8'h10, d); check("R9 full status", d, 32'hB0);
    wr(8'h44, 32'hEE);
    rd(8'h10, d); check("R7 byte overflow sticky", d, 32'hF0);
    rd(8'h10, d); check("R7 overflow still set", d & 32'h40, 32'h40);
    wr(8'h10, 32'h40);
    rd(8'h10, d); check("R7 overflow cleared", d, 32'hB0);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      tx_take(b, ok);
      if (!ok || b != 8'(8'h80 + i)) bad++;
    end
    check("R7 dropped byte absent, order kept", bad, 0);
    check("R7 empty after 16", {31'b0, eng_tx_valid}, 32'h0);
    for (int i = 0; i < 13; i++) wr(8'h44, 32'h10 + i);
    wr(8'h00, 32'h0001_0000);
    wr(8'h4C, 32'hDEADBEEF);
    rd(8'h10, d); check("R7 word overflow with 3 free", d, 32'h1D8);
    wr(8'h10, 32'h40);
    wr(8'h00, 32'h0);
    drain_count(n);
    check("R7 word write dropped entirely", n, 13);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(8'h0C, 32'h10); repeat (3) @(negedge clk);
    check("R10 irq on rx empty", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'h0); repeat (3) @(negedge clk);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    eng_tx_done = 1'b1;
    wr(8'h0C, 32'h01); repeat (3) @(negedge clk);
    check("R10 irq on tx done", {31'b0, irq}, 32'h1);
    rd(8'h10, d); check("R9 tx done bit", d, 32'h99);
    eng_tx_done = 1'b0; eng_rx_done = 1'b1; eng_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 irq follows tx done low", {31'b0, irq}, 32'h0);
    rd(8'h10, d); check("R9 rx done and not ready", d, 32'h1A);
    eng_rx_done = 1'b0; eng_ready = 1'b1;
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(8'h00, 32'h0B01_0401);
    check("R11 enable/idle/div", {26'b0, cfg_enable, cfg_clk_idle, cfg_clk_div}, 32'h3B);
    wr(8'h04, 32'h12345678);
    rd(8'h04, d); check("R11 frames readback", d, 32'h12345678);
    check("R11 frames output", cfg_frames, 32'h12345678);
    wr(8'h50, 32'hFFFFABCD);
    rd(8'h50, d); check("R11 upper frames 16 bit", d, 32'h0000ABCD);
    check("R11 upper frames output", {16'b0, cfg_frames_up}, 32'h0000ABCD);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_rx_full;
    logic [31:0] d; int bad;
    for (int i = 0; i < 16; i++) rx_push(8'h60 + 8'(i));
    check("R12 rx ready low when full", {31'b0, eng_rx_ready}, 32'h0);
    rx_push(8'hEE);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      rd(8'h40, d);
      if (d != 32'h60 + i) bad++;
    end
    check("R12 sixteen bytes in order", bad, 0);
    rd(8'h40, d); check("R12 extra byte not stored", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_byte_tx;
    t_word_tx;
    t_mismatch;
    t_rx_byte;
    t_rx_word;
    t_overflow;
    t_irq;
    t_cfg;
    t_rx_full;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule